// File: doc/BRIEF.md
# Indirect Lookup-Table Access Port

This block gives software a path into a 128-entry by 8-bit lookup table that lives inside the block. The table is never exposed directly. Software loads a pointer register and a data register over a small register bus, then sets a write or read request bit. The block carries out the access over a fixed number of cycles and clears the request bit when it is done. A read leaves the table entry in the data register.

A control bit can make the pointer step forward by one after every finished access. A whole table can then be loaded or dumped with one pointer setup followed by repeated data/request writes. The access time of the slow table is modelled by the parameter `LATENCY`, which must be at least 1. While any request is pending, the block ignores register writes, so the access in flight keeps its operands.

Top module: `tip_indirect_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer, data and control registers all read as 0.
- R2: The register map is as follows. Offset 0 is the pointer (bits 6:0, bit 7 reads 0). Offset 1 is the data register. Offset 2 is control, with bit 0 = auto-advance, bit 1 = write request and bit 2 = read request; its other bits read 0. Offset 3 reads 0. Reads are combinational on `reg_addr`.
- R3: A request bit reads 1 from the edge that sets it. It clears by itself at exactly the `LATENCY`+1-th rising edge after that edge.
- R4: A finished write stores the data register into the table entry the pointer selects. A finished read loads that entry into the data register.
- R5: With auto-advance set, the pointer increases by one at the edge where a request clears, and at no other time. It wraps from 127 to 0.
- R6: With auto-advance clear, a finished access leaves the pointer unchanged.
- R7: If one control write sets both requests, the write runs first and its bit clears after `LATENCY`+1 edges. The read then runs at the pointer as it stands after the write, which has been advanced if auto-advance is on. The read bit clears `2*LATENCY`+2 edges after the setting edge.
- R8: While any request is pending, bus writes to the pointer, data and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register offset for the bus access |
| reg_wdata | input | 8 | Bus write data |
| reg_we | input | 1 | Bus write enable, sampled on the rising edge |
| reg_rdata | output | 8 | Bus read data for `reg_addr` |

## Verification
A wrong latency count or a lost completion shows as a request bit that clears on the wrong edge or never clears. Polling the control register catches this within `LATENCY`+2 cycles of setting the bit. An early or doubled pointer step shows in the pointer read-back right after the access. A write landing at the wrong entry only shows when that entry is read back later, so a full write sweep with auto-advance is followed by a full read sweep against a reference array. Operand corruption during a pending access shows in the pointer value and the table entry read back after completion.

// File: rtl/tip_pkg.sv
// Package: shared offsets and sequencer state for the indirect table port.
// Assumes a 2-bit register offset on the bus.
package tip_pkg;
    localparam logic [1:0] OFS_PTR  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam int CTRL_AUTO = 0;
    localparam int CTRL_WREQ = 1;
    localparam int CTRL_RREQ = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/tip_table_ram.sv
// Module: storage array for the lookup table.
// Synchronous write, combinational read. The contents are not reset.
module tip_table_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data on an enabled edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed entry without delay.
    assign rdata = mem[addr];
endmodule

// File: rtl/tip_sequencer.sv
// Module: runs one table access at a time for LATENCY cycles. A write
// request wins over a read request. Assumes pending bits stay set until
// done is seen and LATENCY >= 1.
module tip_sequencer #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_pend,
    input  logic rd_pend,
    output logic done,
    output logic op_write
);
    import tip_pkg::*;

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LATENCY - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Start an access when a request is pending and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cnt      <= '0;
            op_write <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (wr_pend || rd_pend) begin
                        state    <= SEQ_RUN;
                        cnt      <= CNT_START;
                        op_write <= wr_pend;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // The last cycle of the count is the completion cycle.
    assign done = (state == SEQ_RUN) && (cnt == '0);

    // R7: a write and a read pending together start with the write.
    p_write_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && wr_pend && rd_pend) |=> op_write);

    // R3: an access in flight always has its request still pending.
    p_run_has_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> (wr_pend || rd_pend));

    // R3: the countdown never starts above its programmed value.
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_START);
endmodule

// File: rtl/tip_regfile.sv
// Module: bus-visible pointer, data and control registers. It blocks
// bus writes while an access is pending and applies the completion
// effects. Assumes done pulses only while a request is pending.
module tip_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done,
    input  logic              op_write,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_pend,
    output logic              rd_pend
);
    import tip_pkg::*;

    logic auto_q;
    logic busy;

    assign busy = wr_pend || rd_pend;

    // Accept bus writes when idle; apply completion effects when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            data_q  <= '0;
            auto_q  <= 1'b0;
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
        end else begin
            if (reg_we && !busy) begin
                case (reg_addr)
                    OFS_PTR:  ptr_q  <= reg_wdata[ADDR_W-1:0];
                    OFS_DATA: data_q <= reg_wdata;
                    OFS_CTRL: begin
                        auto_q  <= reg_wdata[CTRL_AUTO];
                        wr_pend <= reg_wdata[CTRL_WREQ];
                        rd_pend <= reg_wdata[CTRL_RREQ];
                    end
                    default: ;
                endcase
            end
            if (done) begin
                if (op_write) begin
                    wr_pend <= 1'b0;
                end else begin
                    rd_pend <= 1'b0;
                    data_q  <= ram_rdata;
                end
                if (auto_q) begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    // Return the register selected by the bus offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_PTR:  reg_rdata = DATA_W'(ptr_q);
            OFS_DATA: reg_rdata = data_q;
            OFS_CTRL: begin
                reg_rdata[CTRL_AUTO] = auto_q;
                reg_rdata[CTRL_WREQ] = wr_pend;
                reg_rdata[CTRL_RREQ] = rd_pend;
            end
            default: ;
        endcase
    end

    // R3: a write request holds until its own completion.
    p_wreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && !(done && op_write)) |=> wr_pend);

    // R3: a read request holds until its own completion.
    p_rreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !(done && !op_write)) |=> rd_pend);

    // R5: auto-advance adds one, modulo the table size.
    p_advance_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && auto_q) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    // R6: without auto-advance the pointer keeps its value.
    p_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !auto_q) |=> $stable(ptr_q));

    // R8: pending operands do not move before completion.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(ptr_q) && $stable(data_q) && $stable(auto_q)));

    // R4: a finished read captures the table output.
    p_read_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_write) |=> (data_q == $past(ram_rdata)));
endmodule

// File: rtl/tip_indirect_port.sv
// Module: top of the indirect table port. It connects the register file,
// the access sequencer and the table storage. Assumes LATENCY >= 1 and
// an 8-bit bus.
module tip_indirect_port #(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ram_rdata;
    logic              wr_pend;
    logic              rd_pend;
    logic              done;
    logic              op_write;
    logic              ram_we;

    assign ram_we = done && op_write;

    tip_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .done      (done),
        .op_write  (op_write),
        .ram_rdata (ram_rdata),
        .ptr_q     (ptr_q),
        .data_q    (data_q),
        .wr_pend   (wr_pend),
        .rd_pend   (rd_pend)
    );

    tip_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pend  (wr_pend),
        .rd_pend  (rd_pend),
        .done     (done),
        .op_write (op_write)
    );

    tip_table_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ptr_q),
        .wdata (data_q),
        .rdata (ram_rdata)
    );
endmodule

// File: tb/tb_tip_indirect_port.sv
module tb_tip_indirect_port;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int DEPTH      = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] ref_mem [DEPTH];

    tip_indirect_port #(.ADDR_W(7), .DATA_W(8), .LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one bus write across one rising edge; returns at the next negedge.
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Count negedges until the masked control bits are clear.
    task automatic wait_clear(input logic [7:0] mask, output int n);
        logic [7:0] c;
        n = 0;
        bus_rd(2'd2, c);
        while ((c & mask) != 0 && n < 1000) begin
            @(negedge clk);
            n++;
            bus_rd(2'd2, c);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset values and the unused offset
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[1:0], v);
            check("R1 reset read", v, 0);
        end

        // R4 / R5: write sweep with auto-advance, pointer wraps at the end
        bus_wr(2'd0, 8'd0);
        bus_wr(2'd2, 8'h01);
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
            bus_wr(2'd1, ref_mem[i]);
            bus_wr(2'd2, 8'h03);
            if (i == 0) begin
                bus_rd(2'd2, v);
                check("R3 write request reads set", v, 8'h03);
            end
            wait_clear(8'h06, n);
            check("R3 write clear edge", n, LAT + 1);
            bus_rd(2'd0, v);
            check("R5 pointer after write", v, (i + 1) % DEPTH);
        end

        // R4 / R5: read sweep with auto-advance
        bus_wr(2'd0, 8'd0);
        for (int i = 0; i < DEPTH; i++) begin
            bus_wr(2'd2, 8'h05);
            // R5: pointer does not move while the read is pending
            bus_rd(2'd0, v);
            check("R5 pointer stable while pending", v, i);
            wait_clear(8'h06, n);
            check("R3 read clear edge", n, LAT + 1);
            bus_rd(2'd1, v);
            check("R4 read data", v, ref_mem[i]);
            bus_rd(2'd0, v);
            check("R5 pointer after read", v, (i + 1) % DEPTH);
        end

        // R6: no auto-advance keeps the pointer
        bus_wr(2'd0, 8'd5);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'h02);
        ref_mem[5] = 8'hC3;
        wait_clear(8'h06, n);
        bus_rd(2'd0, v);
        check("R6 pointer after write", v, 5);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h04);
        wait_clear(8'h06, n);
        bus_rd(2'd1, v);
        check("R6 read back", v, 8'hC3);
        bus_rd(2'd0, v);
        check("R6 pointer after read", v, 5);

        // R8: writes during a pending access are ignored
        bus_wr(2'd0, 8'd10);
        bus_wr(2'd1, 8'h77);
        bus_wr(2'd2, 8'h02);
        bus_wr(2'd0, 8'd20);
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd2, 8'h01);
        ref_mem[10] = 8'h77;
        wait_clear(8'h06, n);
        check("R8 clear edge unchanged", n, LAT + 1 - 3);
        bus_rd(2'd0, v);
        check("R8 pointer kept", v, 10);
        bus_rd(2'd2, v);
        check("R8 control kept", v, 0);
        bus_wr(2'd0, 8'd20);
        bus_wr(2'd2, 8'h04);
        wait_clear(8'h06, n);
        bus_rd(2'd1, v);
        check("R8 entry 20 untouched", v, ref_mem[20]);
        bus_wr(2'd0, 8'd10);
        bus_wr(2'd2, 8'h04);
        wait_clear(8'h06, n);
        bus_rd(2'd1, v);
        check("R8 entry 10 holds first data", v, 8'h77);

        // R7: both requests at once, auto-advance, across the wrap
        bus_wr(2'd0, 8'd127);
        bus_wr(2'd1, 8'h5A);
        bus_wr(2'd2, 8'h07);
        ref_mem[127] = 8'h5A;
        wait_clear(8'h02, n);
        check("R7 write clears first", n, LAT + 1);
        bus_rd(2'd2, v);
        check("R7 read still pending", v, 8'h05);
        wait_clear(8'h04, n);
        check("R7 read clear edge", n + LAT + 1, 2 * LAT + 2);
        bus_rd(2'd1, v);
        check("R7 read after advanced pointer", v, ref_mem[0]);
        bus_rd(2'd0, v);
        check("R7 pointer after both", v, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule